// File: doc/BRIEF.md
# Four-Register Processor Core

A small processor core with four 8-bit general registers, one carry flag, a 4-bit program counter and an instruction register. Its program lives in a 16-word by 8-bit store inside the block. That store is filled through a write port, and the port only accepts writes while the core is held in reset. Once reset is released, the core fetches each instruction into the instruction register in one cycle and executes it in the next. It then repeats this from the program counter.

There are three kinds of instruction. Arithmetic instructions move, add or subtract registers, and each one picks its own carry-in. Branches jump to an absolute 4-bit address, either always or depending on the carry flag. Transfer instructions move a register to or from the 8-bit ports and can also stop the core. The core reports the program counter and whether it has stopped.

Top module: `quad_reg_cpu`

## Requirements
- R1: While reset is asserted, `pc` is 0, `halted` is 0, `outStrobe` is 0 and `outData` is 0. Reset also clears all four registers and the carry flag.
- R2: A write on the program port stores `progData` at `progAddr` only while `rstN` is low. A write made while the core runs changes nothing.
- R3: Each instruction takes two cycles: fetch, then execute. After reset is released, the instruction at word k executes on clock edge 2k+2, and `pc` does not change on a fetch edge.
- R4: Bits 7:6 of an instruction are the opcode, bits 5:4 are the carry-in select, bits 3:2 are the source register and bits 1:0 are the destination register. Register code n selects register Rn.
- R5: Opcode 00 writes source+cin to the destination. Opcode 01 writes source+destination+cin. Opcode 10 writes destination-source-cin, computed as destination plus the inverted source plus the inverted cin.
- R6: The carry-in select gives cin = 0 for code 00, 1 for code 01, the carry flag for code 10 and the inverted carry flag for code 11.
- R7: After an arithmetic instruction, the carry flag holds the adder carry-out, which for subtraction means no borrow. Branches and transfers leave the carry flag unchanged.
- R8: Opcode 11 with bits 5:4 = 01 always jumps to address bits 3:0. With 10 it jumps when carry=1, and with 11 it jumps when carry=0. A branch that is not taken goes to pc+1.
- R9: Bits 7:4 = 1100 mark a transfer. If bit 3 = 1, the register in bits 1:0 is loaded from `inData` on the execute edge.
- R10: A transfer with bit 3 = 0 copies the named register to `outData` and raises `outStrobe` for exactly one cycle. `outData` holds its value until the next such transfer.
- R11: A transfer with bit 2 = 1 halts the core after its transfer. `halted` goes to 1 and `pc` stays on the address of that instruction. No further strobes or state changes happen until reset.
- R12: Any instruction that is neither a taken branch nor a halt advances `pc` by one, wrapping from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; program loading window |
| progWe | input | 1 | Program store write enable |
| progAddr | input | 4 | Program store write address |
| progData | input | 8 | Program store write data |
| inData | input | DATA_W | Input port sampled by load transfers |
| outData | output | DATA_W | Output port register |
| outStrobe | output | 1 | One-cycle pulse marking a new `outData` value |
| halted | output | 1 | Core has stopped |
| pc | output | 4 | Program counter |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- Carry-in selection with the flag both set and clear: a swapped select code would turn 0xF0+0x0F into 0xFF with no carry instead of 0x00 with carry.
- Subtraction with and without borrow, including 0-0-1: an inverted no-borrow sense would report carry where it must not.
- Not-taken branches and the wrap from word 15 to word 0: a wrong condition polarity or a missing wrap would end on a stray halt that outputs 0.
- A program write during a run and the register and flag clear on reset: a store open outside reset, or a register kept across reset, would output nonzero data where zeros are expected.

// File: rtl/qrc_pkg.sv
package qrc_pkg;
  localparam int INSTR_W   = 8;
  localparam int PC_W      = 4;
  localparam int MEM_DEPTH = 1 << PC_W;
  localparam int NUM_REGS  = 4;
  localparam int REG_SEL_W = $clog2(NUM_REGS);

  typedef enum logic [1:0] {
    OP_MOVC = 2'b00,
    OP_ADDC = 2'b01,
    OP_SUBB = 2'b10,
    OP_CTRL = 2'b11
  } opcode_e;

  typedef enum logic [1:0] {
    CIN_ZERO   = 2'b00,
    CIN_ONE    = 2'b01,
    CIN_CARRY  = 2'b10,
    CIN_NCARRY = 2'b11
  } cinSel_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'b00,
    ST_EXEC  = 2'b01,
    ST_HALT  = 2'b10
  } coreState_e;

  typedef struct packed {
    logic                 aluEn;
    opcode_e              op;
    cinSel_e              cinSel;
    logic [REG_SEL_W-1:0] srcSel;
    logic [REG_SEL_W-1:0] dstSel;
    logic                 inLoad;
    logic                 outDrive;
  } ctlStrobe_t;
endpackage

// File: rtl/qrc_alu.sv
module qrc_alu
  import qrc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  opcode_e           op,
  input  cinSel_e           cinSel,
  input  logic              carryFlag,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  output logic [DATA_W-1:0] result,
  output logic              carryOut
);
  logic              cin;
  logic [DATA_W-1:0] opA, opB;
  logic              addIn;
  logic [DATA_W:0]   sum;

  always_comb begin
    unique case (cinSel)
      CIN_ZERO:   cin = 1'b0;
      CIN_ONE:    cin = 1'b1;
      CIN_CARRY:  cin = carryFlag;
      default:    cin = ~carryFlag;
    endcase
  end

  // Subtraction reuses the adder: dst + ~src + ~cin equals dst - src - cin.
  always_comb begin
    unique case (op)
      OP_MOVC: begin opA = srcVal; opB = '0;      addIn = cin;  end
      OP_ADDC: begin opA = srcVal; opB = dstVal;  addIn = cin;  end
      OP_SUBB: begin opA = dstVal; opB = ~srcVal; addIn = ~cin; end
      default: begin opA = '0;     opB = '0;      addIn = 1'b0; end
    endcase
  end

  assign sum      = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, addIn};
  assign result   = sum[DATA_W-1:0];
  assign carryOut = sum[DATA_W];
endmodule

// File: rtl/qrc_datapath.sv
module qrc_datapath
  import qrc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [DATA_W-1:0] inData,
  output logic              carryFlag,
  output logic [DATA_W-1:0] outData,
  output logic              outStrobe
);
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] aluRes;
  logic              aluCarry;
  logic              wrEn;
  logic [DATA_W-1:0] wrData;

  qrc_alu #(.DATA_W(DATA_W)) uAlu (
    .op       (ctl.op),
    .cinSel   (ctl.cinSel),
    .carryFlag(carryFlag),
    .srcVal   (regFile[ctl.srcSel]),
    .dstVal   (regFile[ctl.dstSel]),
    .result   (aluRes),
    .carryOut (aluCarry)
  );

  assign wrEn   = ctl.aluEn | ctl.inLoad;
  assign wrData = ctl.inLoad ? inData : aluRes;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regFile[g] <= '0;
      else if (wrEn && ctl.dstSel == REG_SEL_W'(g)) regFile[g] <= wrData;
    end

    // R4: only the register named by the destination field may change.
    p_reg_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      !(wrEn && ctl.dstSel == REG_SEL_W'(g)) |=> $stable(regFile[g]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) carryFlag <= 1'b0;
    else if (ctl.aluEn) carryFlag <= aluCarry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData   <= '0;
      outStrobe <= 1'b0;
    end else begin
      outStrobe <= ctl.outDrive;
      if (ctl.outDrive) outData <= regFile[ctl.dstSel];
    end
  end

  p_carry_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.aluEn |=> $stable(carryFlag));
  p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    outStrobe |=> !outStrobe);
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.outDrive |=> $stable(outData));
endmodule

// File: rtl/qrc_ctrl.sv
module qrc_ctrl
  import qrc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               progWe,
  input  logic [PC_W-1:0]    progAddr,
  input  logic [INSTR_W-1:0] progData,
  input  logic               carryFlag,
  output ctlStrobe_t         ctl,
  output logic [PC_W-1:0]    pc,
  output logic               halted
);
  logic [INSTR_W-1:0] progMem [MEM_DEPTH];
  logic [INSTR_W-1:0] ir;
  coreState_e         state;
  logic               isCtrl, isXfer, inExec, takeBranch;

  // Program store: writable only while the core sits in reset.
  always_ff @(posedge clk) begin
    if (!rstN && progWe) progMem[progAddr] <= progData;
  end

  assign inExec = (state == ST_EXEC);
  assign isCtrl = (ir[7:6] == 2'b11);
  assign isXfer = isCtrl && (ir[5:4] == 2'b00);

  always_comb begin
    unique case (ir[5:4])
      2'b01:   takeBranch = 1'b1;
      2'b10:   takeBranch = carryFlag;
      2'b11:   takeBranch = ~carryFlag;
      default: takeBranch = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_FETCH;
      pc    <= '0;
      ir    <= '0;
    end else begin
      unique case (state)
        ST_FETCH: begin
          ir    <= progMem[pc];
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (isXfer && ir[2]) begin
            state <= ST_HALT;
          end else begin
            state <= ST_FETCH;
            if (isCtrl && !isXfer && takeBranch) pc <= ir[PC_W-1:0];
            else                                 pc <= pc + 1'b1;
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    ctl.aluEn    = inExec && !isCtrl;
    ctl.op       = opcode_e'(ir[7:6]);
    ctl.cinSel   = cinSel_e'(ir[5:4]);
    ctl.srcSel   = ir[3:2];
    ctl.dstSel   = ir[1:0];
    ctl.inLoad   = inExec && isXfer && ir[3];
    ctl.outDrive = inExec && isXfer && !ir[3];
  end

  assign halted = (state == ST_HALT);

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted && $stable(pc));
  p_fetch_keeps_pc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH) |=> $stable(pc));
  p_seq_advance_r12: assert property (@(posedge clk) disable iff (!rstN)
    (inExec && !isCtrl) |=> pc == $past(pc) + 1'b1);
  p_jump_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inExec && isCtrl && ir[5:4] == 2'b01) |=> pc == $past(ir[PC_W-1:0]));
endmodule

// File: rtl/quad_reg_cpu.sv
module quad_reg_cpu
  import qrc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progWe,
  input  logic [3:0]        progAddr,
  input  logic [7:0]        progData,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData,
  output logic              outStrobe,
  output logic              halted,
  output logic [3:0]        pc
);
  ctlStrobe_t ctl;
  logic       carryFlag;

  qrc_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .progWe   (progWe),
    .progAddr (progAddr),
    .progData (progData),
    .carryFlag(carryFlag),
    .ctl      (ctl),
    .pc       (pc),
    .halted   (halted)
  );

  qrc_datapath #(.DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .inData   (inData),
    .carryFlag(carryFlag),
    .outData  (outData),
    .outStrobe(outStrobe)
  );
endmodule

// File: tb/tb_quad_reg_cpu.sv
module tb_quad_reg_cpu;
  typedef struct packed {
    logic [1:0] op;
    logic [1:0] cc;
    logic       ci;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] res;
    logic       co;
  } vec_t;

  // a goes to R1 (source), b to R2 (destination); res/co are expected R2 and carry.
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 2'b00, 1'b0, 8'h12, 8'h55, 8'h12, 1'b0},
    '{2'b00, 2'b01, 1'b0, 8'hFF, 8'h00, 8'h00, 1'b1},
    '{2'b01, 2'b00, 1'b0, 8'h30, 8'h45, 8'h75, 1'b0},
    '{2'b01, 2'b10, 1'b1, 8'h80, 8'h7F, 8'h00, 1'b1},
    '{2'b01, 2'b11, 1'b1, 8'h01, 8'h02, 8'h03, 1'b0},
    '{2'b01, 2'b11, 1'b0, 8'hF0, 8'h0F, 8'h00, 1'b1},
    '{2'b10, 2'b00, 1'b0, 8'h05, 8'h09, 8'h04, 1'b1},
    '{2'b10, 2'b00, 1'b0, 8'h09, 8'h05, 8'hFC, 1'b0},
    '{2'b10, 2'b01, 1'b0, 8'h05, 8'h05, 8'hFF, 1'b0},
    '{2'b10, 2'b10, 1'b1, 8'h00, 8'h00, 8'hFF, 1'b0},
    '{2'b10, 2'b10, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1},
    '{2'b00, 2'b10, 1'b1, 8'h7F, 8'hAA, 8'h80, 1'b0},
    '{2'b10, 2'b11, 1'b1, 8'h10, 8'h20, 8'h10, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       progWe = 1'b0;
  logic [3:0] progAddr = '0;
  logic [7:0] progData = '0;
  logic [7:0] inData = '0;
  logic [7:0] outData;
  logic       outStrobe;
  logic       halted;
  logic [3:0] pc;

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0] prog [16];
  logic [7:0] capVal [8];
  int         capCyc [8];
  int         capCount = 0;
  int         cycleCnt = 0;
  logic       running = 1'b0;
  logic [3:0] haltPc, latePc;

  quad_reg_cpu dut (
    .clk(clk), .rstN(rstN), .progWe(progWe), .progAddr(progAddr),
    .progData(progData), .inData(inData), .outData(outData),
    .outStrobe(outStrobe), .halted(halted), .pc(pc)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (running) begin
      cycleCnt = cycleCnt + 1;
      if (outStrobe) begin
        if (capCount < 8) begin
          capVal[capCount] = outData;
          capCyc[capCount] = cycleCnt;
        end
        capCount = capCount + 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fillProg(input logic [7:0] filler);
    for (int i = 0; i < 16; i++) prog[i] = filler;
  endtask

  task automatic runProg(input logic [7:0] firstIn, input logic [7:0] secondIn,
                         input bit stray, input logic [3:0] strayAddr,
                         input logic [7:0] strayData);
    rstN = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      progWe = 1'b1; progAddr = 4'(i); progData = prog[i];
      @(negedge clk);
    end
    progWe = 1'b0;
    #1;
    capCount = 0; cycleCnt = 0;
    inData = firstIn;
    rstN = 1'b1;
    running = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    inData = secondIn;
    if (stray) begin
      progWe = 1'b1; progAddr = strayAddr; progData = strayData;
      @(negedge clk);
      progWe = 1'b0;
    end
    for (int w = 0; w < 400 && !halted; w++) @(negedge clk);
    if (!halted) check("watchdog R11", 0, 1);
    haltPc = pc;
    repeat (8) @(negedge clk);
    latePc = pc;
    running = 1'b0;
  endtask

  initial begin
    // R1: state held in reset
    repeat (3) @(negedge clk);
    check("R1 pc", pc, 0);
    check("R1 halted", halted, 0);
    check("R1 outStrobe", outStrobe, 0);
    check("R1 outData", outData, 0);

    // Table of arithmetic vectors (R4 R5 R6 R7 R9 R10 R3)
    for (int v = 0; v < NV; v++) begin
      fillProg(8'hC4);
      prog[0] = 8'hC9;                                 // load R1
      prog[1] = 8'hCA;                                 // load R2
      prog[2] = VECS[v].ci ? 8'h83 : 8'h93;            // preset carry
      prog[3] = {VECS[v].op, VECS[v].cc, 2'b01, 2'b10};
      prog[4] = 8'hC2;                                 // out R2
      prog[5] = 8'h23;                                 // R3 = R0 + carry
      prog[6] = 8'hC7;                                 // out R3, halt
      runProg(VECS[v].a, VECS[v].b, 1'b0, 4'd0, 8'h00);
      check($sformatf("R5 R6 result vec %0d", v), capVal[0], VECS[v].res);
      check($sformatf("R7 carry vec %0d", v), capVal[1], VECS[v].co);
      check($sformatf("R10 strobe count vec %0d", v), capCount, 2);
      check($sformatf("R3 exec cycle vec %0d", v), capCyc[0], 10);
      check($sformatf("R11 halt pc vec %0d", v), haltPc, 6);
    end

    // R8: taken/not-taken branches on both carry polarities
    fillProg(8'hC4);
    prog[0] = 8'hC9; prog[1] = 8'h83; prog[2] = 8'hE5; prog[5] = 8'hF3;
    prog[6] = 8'hDC; prog[8] = 8'hC7; prog[12] = 8'hC1; prog[13] = 8'h93;
    prog[14] = 8'hEA; prog[15] = 8'hF8;
    runProg(8'h5A, 8'h5A, 1'b0, 4'd0, 8'h00);
    check("R8 branch path out0", capVal[0], 8'h5A);
    check("R8 branch path out1", capVal[1], 8'hFF);
    check("R8 branch strobes", capCount, 2);
    check("R8 branch halt pc", haltPc, 8);

    // R12 wrap 15->0, R2 write during run ignored
    fillProg(8'hC4);
    prog[0] = 8'hE2; prog[1] = 8'hDF; prog[2] = 8'h53; prog[3] = 8'hC7;
    prog[15] = 8'h83;
    runProg(8'h00, 8'h00, 1'b1, 4'd3, 8'hC4);
    check("R12 wrap result", capVal[0], 8'h01);
    check("R2 run write ignored strobes", capCount, 1);
    check("R12 wrap halt pc", haltPc, 3);
    check("R11 pc frozen after halt", latePc, haltPc);
    check("R11 still halted", halted, 1);

    // R9 load with halt, leaves carry=1 and R3=0x5A before the reset below
    fillProg(8'hC4);
    prog[0] = 8'h83; prog[1] = 8'hCF;
    runProg(8'h5A, 8'h5A, 1'b0, 4'd0, 8'h00);
    check("R9 load+halt no strobe", capCount, 0);
    check("R9 load+halt pc", haltPc, 1);

    rstN = 1'b0;
    @(negedge clk);
    check("R1 pc after halt", pc, 0);
    check("R1 halted cleared", halted, 0);

    // R1: registers and carry cleared by reset
    fillProg(8'hC4);
    prog[0] = 8'hC3; prog[1] = 8'hC2; prog[2] = 8'h23; prog[3] = 8'hC7;
    runProg(8'h00, 8'h00, 1'b0, 4'd0, 8'h00);
    check("R1 R3 cleared", capVal[0], 0);
    check("R1 R2 cleared", capVal[1], 0);
    check("R1 carry cleared", capVal[2], 0);
    check("R10 strobes", capCount, 3);
    check("R10 outData held", outData, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog R11: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule